// File: doc/BRIEF.md
# Parallel Bit Gather/Scatter Unit

This block moves operand bits to new positions under the control of a mask. It has two operations, picked per request. Gather takes the data bits that sit under set mask bits and packs them into the low end of the result. Scatter does the reverse: it takes the low-order data bits and places them at the set mask positions, with zeros everywhere else. In both operations, bit order is kept. The mask therefore routes each bit in a data-dependent way, which a fixed shift or permutation cannot do.

A width-select input picks 64-bit or 32-bit operation for each request. In 32-bit operation, the upper halves of both operands play no part and the upper half of the result is zero. A request is presented with `valid_in`. The result is registered and appears with `valid_out` on the following cycle. The result stays unchanged until the next request or a reset.

Top module: `bit_route_unit`

## Requirements
- R1: With `op_sel`=0 (gather), the data bit at the lowest set mask position goes to result bit 0, the next set position to bit 1, and so on upward. Example: mask 8'h65 with data 8'hB6 gives 8'h06.
- R2: In gather, every result bit at index greater than or equal to the number of set mask bits is 0.
- R3: With `op_sel`=1 (scatter), data bits 0, 1, 2, ... are placed in order at the set mask positions, starting from the lowest. Example: mask 8'h65 with data 8'hB6 gives 8'h24.
- R4: In scatter, every result bit whose mask bit is clear is 0.
- R5: With `wide_sel`=0 (32-bit), operand bits 63:32 have no effect and result bits 63:32 are 0. With `wide_sel`=1, all 64 bits are used.
- R6: A zero mask gives a zero result in both operations. An all-ones mask returns the data unchanged, limited to the active width, in both operations.
- R7: The result loads on a clock edge where `valid_in` is 1, and `valid_out` is 1 exactly in the cycle after each such edge. Back-to-back requests produce back-to-back results.
- R8: While `valid_in` is 0, `result_out` holds its value and `valid_out` is 0.
- R9: A synchronous active-high `rst` clears `valid_out` and `result_out`, and takes priority over a request in the same cycle.
- R10: Scattering a gather result back with the same mask gives data AND mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Request strobe |
| op_sel | input | 1 | 0 = gather, 1 = scatter |
| wide_sel | input | 1 | 1 = 64-bit, 0 = 32-bit |
| data_in | input | 64 | Data operand |
| mask_in | input | 64 | Mask operand |
| valid_out | output | 1 | Result valid, one cycle after request |
| result_out | output | 64 | Registered result |

## Verification
The checker watches the following on every cycle:
- the handshake timing, result hold and reset clearing;
- the zero bits above the selected count after a gather;
- the cleared non-mask bits after a scatter;
- the zero upper half in 32-bit operation;
- the zero-mask and full-mask cases.

The exact placement and ordering of the moved bits can only be shown by the bench. It does this with its table of worked vectors and its random operands compared against an independently written reference. The gather-then-scatter identity and reset priority over a simultaneous request are also scenario-only checks.

// File: rtl/bru_pkg.sv
package bru_pkg;
  typedef enum logic {
    BRU_OP_GATHER  = 1'b0,
    BRU_OP_SCATTER = 1'b1
  } bru_op_e;

  typedef enum logic {
    BRU_W_NARROW = 1'b0,
    BRU_W_WIDE   = 1'b1
  } bru_width_e;
endpackage

// File: rtl/bru_width_gate.sv
module bru_width_gate #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  bru_pkg::bru_width_e width,
  input  logic [DATA_W-1:0]   word_in,
  output logic [DATA_W-1:0]   word_out
);
  localparam int HIGH_W = DATA_W - NARROW_W;

  generate
    if (HIGH_W > 0) begin : g_gate
      assign word_out = (width == bru_pkg::BRU_W_WIDE) ? word_in
                      : {{HIGH_W{1'b0}}, word_in[NARROW_W-1:0]};
    end else begin : g_pass
      assign word_out = word_in;
    end
  endgenerate
endmodule

// File: rtl/bru_rank.sv
module bru_rank #(
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic [DATA_W-1:0]            mask,
  output logic [DATA_W-1:0][IDX_W-1:0] rank,
  output logic [CNT_W-1:0]             total
);
  // rank[i] = number of set mask bits strictly below position i
  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] run,
                                            input logic bit_in);
    return run + CNT_W'(bit_in);
  endfunction

  always_comb begin
    logic [CNT_W-1:0] run;
    run = '0;
    for (int i = 0; i < DATA_W; i++) begin
      rank[i] = run[IDX_W-1:0];
      run     = bump(run, mask[i]);
    end
    total = run;
  end
endmodule

// File: rtl/bru_gather.sv
module bru_gather #(
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]            data,
  input  logic [DATA_W-1:0]            mask,
  input  logic [DATA_W-1:0][IDX_W-1:0] rank,
  output logic [DATA_W-1:0]            packed_out
);
  // each selected bit lands at its rank; unselected slots stay zero
  always_comb begin
    packed_out = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (mask[i]) packed_out[rank[i]] = data[i];
    end
  end
endmodule

// File: rtl/bru_scatter.sv
module bru_scatter #(
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]            data,
  input  logic [DATA_W-1:0]            mask,
  input  logic [DATA_W-1:0][IDX_W-1:0] rank,
  output logic [DATA_W-1:0]            spread_out
);
  // each set mask position pulls the data bit whose index is its rank
  generate
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_slot
      assign spread_out[gi] = mask[gi] & data[rank[gi]];
    end
  endgenerate
endmodule

// File: rtl/bru_result_reg.sv
module bru_result_reg #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] next_word,
  output logic [DATA_W-1:0] word_q,
  output logic              valid_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= load;
      if (load) word_q <= next_word;
    end
  end
endmodule

// File: rtl/bit_route_unit.sv
module bit_route_unit #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_in,
  input  logic              op_sel,
  input  logic              wide_sel,
  input  logic [DATA_W-1:0] data_in,
  input  logic [DATA_W-1:0] mask_in,
  output logic              valid_out,
  output logic [DATA_W-1:0] result_out
);
  import bru_pkg::*;

  localparam int IDX_W = $clog2(DATA_W);
  localparam int CNT_W = IDX_W + 1;

  bru_op_e                      op_e;
  bru_width_e                   width_e;
  logic [DATA_W-1:0]            data_eff;
  logic [DATA_W-1:0]            mask_eff;
  logic [DATA_W-1:0][IDX_W-1:0] rank;
  logic [CNT_W-1:0]             sel_count;
  logic [DATA_W-1:0]            gathered;
  logic [DATA_W-1:0]            scattered;
  logic [DATA_W-1:0]            next_result;

  assign op_e    = bru_op_e'(op_sel);
  assign width_e = bru_width_e'(wide_sel);

  bru_width_gate #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_gate_data (
    .width(width_e), .word_in(data_in), .word_out(data_eff)
  );

  bru_width_gate #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_gate_mask (
    .width(width_e), .word_in(mask_in), .word_out(mask_eff)
  );

  bru_rank #(.DATA_W(DATA_W)) u_rank (
    .mask(mask_eff), .rank(rank), .total(sel_count)
  );

  bru_gather #(.DATA_W(DATA_W)) u_gather (
    .data(data_eff), .mask(mask_eff), .rank(rank), .packed_out(gathered)
  );

  bru_scatter #(.DATA_W(DATA_W)) u_scatter (
    .data(data_eff), .mask(mask_eff), .rank(rank), .spread_out(scattered)
  );

  assign next_result = (op_e == BRU_OP_SCATTER) ? scattered : gathered;

  bru_result_reg #(.DATA_W(DATA_W)) u_result (
    .clk(clk), .rst(rst), .load(valid_in), .next_word(next_result),
    .word_q(result_out), .valid_q(valid_out)
  );
endmodule

// File: rtl/bru_chk.sv
module bru_chk #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  localparam int CNT_W   = $clog2(DATA_W) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              valid_in,
  input logic              op_sel,
  input logic              wide_sel,
  input logic [DATA_W-1:0] data_in,
  input logic [DATA_W-1:0] mask_in,
  input logic [DATA_W-1:0] mask_eff,
  input logic [CNT_W-1:0]  sel_count,
  input logic              valid_out,
  input logic [DATA_W-1:0] result_out
);
  logic rst_q = 1'b0;

  always_ff @(posedge clk) rst_q <= rst;

  // R9: one edge after reset, outputs are cleared
  always @(negedge clk) begin
    if (rst_q) begin
      assert_reset_clear_R9: assert (!valid_out && result_out == '0);
    end
  end

  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> valid_out);

  assert_valid_drops_R8: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> !valid_out);

  assert_result_holds_R8: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> $stable(result_out));

  assert_gather_top_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (valid_in && !op_sel) |=> ((result_out >> $past(sel_count)) == '0));

  assert_scatter_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (valid_in && op_sel) |=> ((result_out & ~$past(mask_eff)) == '0));

  assert_narrow_upper_R5: assert property (@(posedge clk) disable iff (rst)
    (valid_in && !wide_sel) |=> (result_out[DATA_W-1:NARROW_W] == '0));

  assert_zero_mask_R6: assert property (@(posedge clk) disable iff (rst)
    (valid_in && mask_eff == '0) |=> (result_out == '0));

  assert_full_mask_R6: assert property (@(posedge clk) disable iff (rst)
    (valid_in && wide_sel && (&mask_in)) |=> (result_out == $past(data_in)));
endmodule

bind bit_route_unit bru_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_bru_chk (
  .clk(clk), .rst(rst), .valid_in(valid_in), .op_sel(op_sel),
  .wide_sel(wide_sel), .data_in(data_in), .mask_in(mask_in),
  .mask_eff(mask_eff), .sel_count(sel_count), .valid_out(valid_out),
  .result_out(result_out)
);

// File: tb/tb_bit_route_unit.sv
`timescale 1ns/1ps
module tb_bit_route_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_in = 1'b0;
  logic        op_sel = 1'b0;
  logic        wide_sel = 1'b1;
  logic [63:0] data_in = '0;
  logic [63:0] mask_in = '0;
  logic        valid_out;
  logic [63:0] result_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bit_route_unit dut (
    .clk(clk), .rst(rst), .valid_in(valid_in), .op_sel(op_sel),
    .wide_sel(wide_sel), .data_in(data_in), .mask_in(mask_in),
    .valid_out(valid_out), .result_out(result_out)
  );

  localparam int N_VEC = 12;
  localparam bit V_OP [N_VEC] = '{0, 1, 0, 1, 0, 1, 0, 1, 0, 1, 0, 1};
  localparam bit V_WIDE [N_VEC] = '{1, 1, 1, 1, 0, 0, 1, 1, 1, 0, 1, 1};
  localparam logic [63:0] V_DATA [N_VEC] = '{
    64'h0000_0000_0000_00B6, 64'h0000_0000_0000_00B6,
    64'hFFFF_0000_FFFF_0000, 64'h0000_0000_0000_00A5,
    64'hFFFF_FFFF_1234_5678, 64'hDEAD_BEEF_0000_00FF,
    64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_CAFE_F00D,
    64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001};
  localparam logic [63:0] V_MASK [N_VEC] = '{
    64'h0000_0000_0000_0065, 64'h0000_0000_0000_0065,
    64'hFF00_FF00_FF00_FF00, 64'h8000_0000_0000_0F01,
    64'hFFFF_FFFF_FFFF_0000, 64'hFFFF_FFFF_F0F0_F0F0,
    64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000,
    64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000};
  localparam logic [63:0] V_EXP [N_VEC] = '{
    64'h0000_0000_0000_0006, 64'h0000_0000_0000_0024,
    64'h0000_0000_FF00_FF00, 64'h8000_0000_0000_0201,
    64'h0000_0000_0000_1234, 64'h0000_0000_0000_F0F0,
    64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000,
    64'h0123_4567_89AB_CDEF, 64'h0000_0000_CAFE_F00D,
    64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000};

  function automatic string row_tag(int i);
    case (i)
      0, 2, 10: return "R1";
      1, 3, 11: return "R3";
      4, 5:     return "R5";
      default:  return "R6";
    endcase
  endfunction

  // reference: k-th result bit comes from the k-th set mask bit
  function automatic logic [63:0] ref_gather(logic [63:0] d, logic [63:0] m, bit wide);
    logic [63:0] r = '0;
    int pos = 0;
    if (!wide) begin d[63:32] = '0; m[63:32] = '0; end
    for (int k = 0; k < 64; k++) begin
      while (pos < 64 && !m[pos]) pos++;
      if (pos < 64) begin r[k] = d[pos]; pos++; end
    end
    return r;
  endfunction

  // reference: data bit j goes to the j-th set mask bit
  function automatic logic [63:0] ref_scatter(logic [63:0] d, logic [63:0] m, bit wide);
    logic [63:0] r = '0;
    int pos = 0;
    if (!wide) begin d[63:32] = '0; m[63:32] = '0; end
    for (int j = 0; j < 64; j++) begin
      while (pos < 64 && !m[pos]) pos++;
      if (pos < 64) begin r[pos] = d[j]; pos++; end
    end
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one request; returns result and valid sampled a cycle later
  task automatic run_op(bit op, bit wide, logic [63:0] d, logic [63:0] m,
                        output logic [63:0] res, output logic vo);
    @(negedge clk);
    op_sel = op; wide_sel = wide; data_in = d; mask_in = m; valid_in = 1'b1;
    @(negedge clk);
    valid_in = 1'b0;
    res = result_out;
    vo  = valid_out;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] res, res2, hold_val, d, m;
    logic vo;

    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9 reset valid_out", {63'd0, valid_out}, 64'd0);
    check("R9 reset result", result_out, 64'd0);
    rst = 1'b0;

    // table of worked vectors (R1 R3 R5 R6)
    for (int i = 0; i < N_VEC; i++) begin
      run_op(V_OP[i], V_WIDE[i], V_DATA[i], V_MASK[i], res, vo);
      check({row_tag(i), " table valid"}, {63'd0, vo}, 64'd1);
      check({row_tag(i), " table result"}, res, V_EXP[i]);
    end

    // R8: hold while valid_in low, with changing operands
    hold_val = result_out;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      data_in = {$urandom, $urandom}; mask_in = {$urandom, $urandom};
      op_sel = ~op_sel;
      @(negedge clk);
      check("R8 hold result", result_out, hold_val);
      check("R8 valid low", {63'd0, valid_out}, 64'd0);
    end

    // R7: back-to-back requests
    @(negedge clk);
    op_sel = 1'b0; wide_sel = 1'b1; data_in = 64'h00F0; mask_in = 64'h00FF; valid_in = 1'b1;
    @(negedge clk);
    op_sel = 1'b1; data_in = 64'h0003; mask_in = 64'h0300;
    check("R7 first of pair", result_out, 64'h00F0);
    check("R7 first valid", {63'd0, valid_out}, 64'd1);
    @(negedge clk);
    valid_in = 1'b0;
    check("R7 second of pair", result_out, 64'h0300);
    check("R7 second valid", {63'd0, valid_out}, 64'd1);
    @(negedge clk);
    check("R7 valid drops", {63'd0, valid_out}, 64'd0);

    // random operands against reference, plus R2 R4 R10
    for (int n = 0; n < 60; n++) begin
      bit wide;
      wide = (n % 3) != 0;
      d = {$urandom, $urandom};
      m = {$urandom, $urandom};
      if (n % 5 == 0) m = m & {$urandom, $urandom};
      run_op(1'b0, wide, d, m, res, vo);
      check(wide ? "R1 random gather" : "R5 random gather", res, ref_gather(d, m, wide));
      check("R2 gather upper zero",
            res >> $countones(wide ? m : {32'd0, m[31:0]}), 64'd0);
      run_op(1'b1, wide, res, m, res2, vo);
      check("R10 gather then scatter",
            res2, wide ? (d & m) : {32'd0, d[31:0] & m[31:0]});
      run_op(1'b1, wide, d, m, res, vo);
      check(wide ? "R3 random scatter" : "R5 random scatter", res, ref_scatter(d, m, wide));
      check("R4 scatter outside mask", res & ~m, 64'd0);
    end

    // R9: reset wins over a request in the same cycle
    @(negedge clk);
    op_sel = 1'b0; wide_sel = 1'b1; data_in = '1; mask_in = '1; valid_in = 1'b1; rst = 1'b1;
    @(negedge clk);
    valid_in = 1'b0;
    check("R9 reset priority valid", {63'd0, valid_out}, 64'd0);
    check("R9 reset priority result", result_out, 64'd0);
    rst = 1'b0;
    run_op(1'b0, 1'b1, 64'h5, 64'h5, res, vo);
    check("R9 operation after reset", res, 64'h3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule